// File: doc/BRIEF.md
# Boundary-Scan Pin Redirection Chain

This block sits between a chip's IO pads and its peripheral logic. Every pin passes through it. Each pin is one of four kinds, fixed at elaboration: input-only, output-only, bidirectional with a permanently driven output, or tristate with its own output enable. A serial register chain runs through all the pins. It is clocked by the test clock and loaded through a test data input. Capture, shift and update strobes from an external test controller steer it.

Each pin owns one control cell in the chain. With the control cell's latch clear, the pin is transparent: pad and peripheral are wired straight together. With it set, the pin is cut in the middle. The pad side is driven from its own pad-side cells, and the peripheral side is driven from its own core-side cells. Those same cells sample what each side presents, so a pad can be tested apart from its peripheral and a peripheral apart from its pad.

Every cell has a shift stage and a separate update latch. Bits can therefore be shifted through the chain without disturbing the pins until an update strobe copies them across.

Top module: `bscan_chain`

## Requirements
- R1: The kind of pin p is set by bits [2p+1:2p] of `PIN_KINDS`: 0 is input-only (3 cells), 1 is output-only (3 cells), 2 is bidirectional (5 cells), 3 is tristate (7 cells). Pin 0 is nearest TDI and the last pin is nearest TDO. Inside a pin, the cells run from the TDI end in this order: the control cell; then the pad-side cells for in, out and oe, where present; then the core-side cells for in, out and oe, where present. The control cell of each pin governs that pin alone.
- R2: While a pin's control latch is 0, the pin is transparent. `core_i` equals `pad_i`, `pad_o` equals `core_o`, and `pad_oe` equals `core_oe` on tristate pins. Chain contents have no effect on the pin in this state.
- R3: While a pin's control latch is 1, the pin is redirected. `core_i` comes from the core-side in latch, and `pad_o` and `pad_oe` come from the pad-side out and oe latches. Changes on `pad_i`, `core_o` and `core_oe` do not reach the other side.
- R4: On a capture edge, each cell's shift stage loads a value. The pad-side in cell loads `pad_i`. The core-side out cell loads `core_o` and the core-side oe cell loads `core_oe`. Every other cell (control, pad-side out and oe, core-side in) loads its own update latch.
- R5: On a shift edge, every shift stage takes the bit of its neighbour on the TDI side, and the first cell takes `tdi`. `tdo` always shows the shift stage of the cell nearest TDO.
- R6: Update latches change only on a clock edge where `update_en` is high and both `capture_en` and `shift_en` are low. When strobes are raised together, capture takes priority over shift, and shift over update.
- R7: An asynchronous low level on `trst_n` clears all shift stages and update latches, so every pin is transparent.
- R8: A single control latch redirects both the pad side and the core side of its pin together.
- R9: Pins without a core input drive `core_i` to 0. Pins without a pad output drive `pad_o` to 0. `pad_oe` is 0 for input-only pins and 1 for output-only and bidirectional pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low chain reset |
| tdi | input | 1 | Serial data into the first cell |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| tdo | output | 1 | Serial data from the last cell |
| pad_i | input | NUM_PINS | Values arriving from the pads |
| pad_o | output | NUM_PINS | Values driven to the pads |
| pad_oe | output | NUM_PINS | Output enables to the pads |
| core_i | output | NUM_PINS | Values delivered to the peripherals |
| core_o | input | NUM_PINS | Values driven by the peripherals |
| core_oe | input | NUM_PINS | Output enables from the peripherals |

## Verification
The checker watches several properties on every clock edge. It confirms that transparent pins pass `pad_i` and `core_o` straight through. It confirms that the control latches move only on a clean update, and that the redirected outputs of a pin in scan mode stay frozen whatever the other side does between updates. It also confirms that reset leaves every pin transparent.

Some behaviour only the bench's scenarios can show. These are the exact cell order and capture sources, read back serially through `tdo` against a model. They also include the strobe priority when capture and update coincide, and a single tristate pin redirected while its neighbours stay transparent.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        PK_INPUT    = 2'd0,
        PK_OUTPUT   = 2'd1,
        PK_BIDIR    = 2'd2,
        PK_TRISTATE = 2'd3
    } pin_kind_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_CAPTURE,
        OP_SHIFT,
        OP_UPDATE
    } cell_op_e;

    function automatic bit kind_has_in(logic [1:0] k);
        return k != PK_OUTPUT;
    endfunction

    function automatic bit kind_has_out(logic [1:0] k);
        return k != PK_INPUT;
    endfunction

    function automatic bit kind_has_oe(logic [1:0] k);
        return k == PK_TRISTATE;
    endfunction

    function automatic int kind_signals(logic [1:0] k);
        return int'(kind_has_in(k)) + int'(kind_has_out(k)) + int'(kind_has_oe(k));
    endfunction

    function automatic int kind_cells(logic [1:0] k);
        return 1 + 2 * kind_signals(k);
    endfunction

    function automatic cell_op_e decode_op(logic cap, logic sh, logic upd);
        if (cap)      return OP_CAPTURE;
        else if (sh)  return OP_SHIFT;
        else if (upd) return OP_UPDATE;
        else          return OP_HOLD;
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  cell_op_e op,
    input  logic     scan_in,
    input  logic     cap_val,
    output logic     shift_q,
    output logic     upd_q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            shift_q <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            unique case (op)
                OP_HOLD:    ;
                OP_CAPTURE: shift_q <= cap_val;
                OP_SHIFT:   shift_q <= scan_in;
                OP_UPDATE:  upd_q   <= shift_q;
            endcase
        end
    end

endmodule

// File: rtl/bscan_pin.sv
module bscan_pin
    import bscan_pkg::*;
#(
    parameter logic [1:0] KIND = 2'd3
) (
    input  logic     tck,
    input  logic     trst_n,
    input  cell_op_e op,
    input  logic     scan_in,
    output logic     scan_out,
    input  logic     pad_in,
    input  logic     core_out,
    input  logic     core_oe_in,
    output logic     core_in,
    output logic     pad_out,
    output logic     pad_oe,
    output logic     scan_mode
);

    localparam bit HAS_I     = kind_has_in(KIND);
    localparam bit HAS_O     = kind_has_out(KIND);
    localparam bit HAS_OE    = kind_has_oe(KIND);
    localparam int NSIG      = kind_signals(KIND);
    localparam int LEN       = kind_cells(KIND);
    localparam int POS_I     = 0;
    localparam int POS_O     = HAS_I ? 1 : 0;
    localparam int POS_OE    = POS_O + 1;
    localparam int PAD_BASE  = 1;
    localparam int CORE_BASE = 1 + NSIG;

    logic [LEN-1:0] sh;
    logic [LEN-1:0] upd;

    for (genvar j = 0; j < LEN; j++) begin : g_cell
        logic cap_bit;
        logic si_bit;

        if (j == 0) begin : g_first
            assign si_bit = scan_in;
        end else begin : g_next
            assign si_bit = sh[j-1];
        end

        if (HAS_I && j == PAD_BASE + POS_I) begin : g_cap_pad_in
            assign cap_bit = pad_in;
        end else if (HAS_O && j == CORE_BASE + POS_O) begin : g_cap_core_out
            assign cap_bit = core_out;
        end else if (HAS_OE && j == CORE_BASE + POS_OE) begin : g_cap_core_oe
            assign cap_bit = core_oe_in;
        end else begin : g_cap_self
            assign cap_bit = upd[j];
        end

        bscan_cell u_cell (
            .tck     (tck),
            .trst_n  (trst_n),
            .op      (op),
            .scan_in (si_bit),
            .cap_val (cap_bit),
            .shift_q (sh[j]),
            .upd_q   (upd[j])
        );
    end

    assign scan_mode = upd[0];
    assign scan_out  = sh[LEN-1];

    if (HAS_I) begin : g_in
        assign core_in = scan_mode ? upd[CORE_BASE + POS_I] : pad_in;
    end else begin : g_no_in
        logic unused_pad_in;
        assign unused_pad_in = pad_in;
        assign core_in = 1'b0;
    end

    if (HAS_O) begin : g_out
        assign pad_out = scan_mode ? upd[PAD_BASE + POS_O] : core_out;
    end else begin : g_no_out
        logic unused_core_out;
        assign unused_core_out = core_out;
        assign pad_out = 1'b0;
    end

    if (HAS_OE) begin : g_oe
        assign pad_oe = scan_mode ? upd[PAD_BASE + POS_OE] : core_oe_in;
    end else begin : g_no_oe
        logic unused_core_oe;
        assign unused_core_oe = core_oe_in;
        assign pad_oe = HAS_O;
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int                    NUM_PINS  = 4,
    parameter logic [2*NUM_PINS-1:0] PIN_KINDS = 8'hE4
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                tdi,
    input  logic                capture_en,
    input  logic                shift_en,
    input  logic                update_en,
    output logic                tdo,
    input  logic [NUM_PINS-1:0] pad_i,
    output logic [NUM_PINS-1:0] pad_o,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] core_i,
    input  logic [NUM_PINS-1:0] core_o,
    input  logic [NUM_PINS-1:0] core_oe
);

    cell_op_e            op;
    logic [NUM_PINS:0]   link;
    logic [NUM_PINS-1:0] pin_scan;

    always_comb begin
        op = decode_op(capture_en, shift_en, update_en);
    end

    assign link[0] = tdi;
    assign tdo     = link[NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        bscan_pin #(
            .KIND (PIN_KINDS[2*p +: 2])
        ) u_pin (
            .tck        (tck),
            .trst_n     (trst_n),
            .op         (op),
            .scan_in    (link[p]),
            .scan_out   (link[p+1]),
            .pad_in     (pad_i[p]),
            .core_out   (core_o[p]),
            .core_oe_in (core_oe[p]),
            .core_in    (core_i[p]),
            .pad_out    (pad_o[p]),
            .pad_oe     (pad_oe[p]),
            .scan_mode  (pin_scan[p])
        );
    end

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk
    import bscan_pkg::*;
#(
    parameter int                    NUM_PINS  = 4,
    parameter logic [2*NUM_PINS-1:0] PIN_KINDS = 8'hE4
) (
    input logic                tck,
    input logic                trst_n,
    input logic                capture_en,
    input logic                shift_en,
    input logic                update_en,
    input logic [NUM_PINS-1:0] pad_i,
    input logic [NUM_PINS-1:0] core_o,
    input logic [NUM_PINS-1:0] pad_o,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] core_i,
    input logic [NUM_PINS-1:0] pin_scan
);

    logic clean_update;
    assign clean_update = update_en && !capture_en && !shift_en;

    // R6: control latches move only on a clean update
    a_r6_ctrl_hold: assert property (@(posedge tck) disable iff (!trst_n)
        !clean_update |=> $stable(pin_scan));

    // R7: reset leaves every pin transparent
    a_r7_reset_pass: assert property (@(posedge tck)
        !trst_n |-> (pin_scan == '0));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        if (kind_has_in(PIN_KINDS[2*p +: 2])) begin : g_in
            a_r2_in_pass: assert property (@(posedge tck) disable iff (!trst_n)
                !pin_scan[p] |-> (core_i[p] == pad_i[p]));
            a_r3_core_frozen: assert property (@(posedge tck) disable iff (!trst_n)
                (pin_scan[p] && !clean_update) |=> $stable(core_i[p]));
        end
        if (kind_has_out(PIN_KINDS[2*p +: 2])) begin : g_out
            a_r2_out_pass: assert property (@(posedge tck) disable iff (!trst_n)
                !pin_scan[p] |-> (pad_o[p] == core_o[p]));
            a_r8_pad_frozen: assert property (@(posedge tck) disable iff (!trst_n)
                (pin_scan[p] && !clean_update) |=> ($stable(pad_o[p]) && $stable(pad_oe[p])));
        end
    end

endmodule

bind bscan_chain bscan_chain_chk #(
    .NUM_PINS  (NUM_PINS),
    .PIN_KINDS (PIN_KINDS)
) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .pad_i      (pad_i),
    .core_o     (core_o),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe),
    .core_i     (core_i),
    .pin_scan   (pin_scan)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int L  = 18;

    logic          tck = 1'b0;
    logic          trst_n = 1'b1;
    logic          tdi = 1'b0;
    logic          capture_en = 1'b0;
    logic          shift_en = 1'b0;
    logic          update_en = 1'b0;
    logic          tdo;
    logic [NP-1:0] pad_i = '0;
    logic [NP-1:0] pad_o;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] core_i;
    logic [NP-1:0] core_o = '0;
    logic [NP-1:0] core_oe = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [L-1:0] m_sh  = '0;
    logic [L-1:0] m_upd = '0;

    typedef struct {
        int            sel;
        logic [NP-1:0] exp;
        string         req;
    } item_t;

    item_t sb_q[$];
    item_t it;
    logic [NP-1:0] act;

    always #(CLK_PERIOD/2) tck = ~tck;

    bscan_chain #(.NUM_PINS(NP), .PIN_KINDS(8'hE4)) uut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .tdo(tdo), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
        .core_i(core_i), .core_o(core_o), .core_oe(core_oe)
    );

    // monitor: pops every queued expectation at the falling edge
    always @(negedge tck) begin
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.sel)
                0:       act = {3'b000, tdo};
                1:       act = core_i;
                2:       act = pad_o;
                default: act = pad_oe;
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s sel=%0d actual=%b expected=%b", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    task automatic push(int sel, logic [NP-1:0] e, string req);
        item_t n;
        n.sel = sel;
        n.exp = e;
        n.req = req;
        sb_q.push_back(n);
    endtask

    // expected pin outputs from the model of the update latches
    task automatic check_pins(string req);
        logic [NP-1:0] ci, po, poe;
        ci[0]  = m_upd[0]  ? m_upd[2]  : pad_i[0];
        ci[1]  = 1'b0;
        ci[2]  = m_upd[6]  ? m_upd[9]  : pad_i[2];
        ci[3]  = m_upd[11] ? m_upd[15] : pad_i[3];
        po[0]  = 1'b0;
        po[1]  = m_upd[3]  ? m_upd[4]  : core_o[1];
        po[2]  = m_upd[6]  ? m_upd[8]  : core_o[2];
        po[3]  = m_upd[11] ? m_upd[13] : core_o[3];
        poe[0] = 1'b0;
        poe[1] = 1'b1;
        poe[2] = 1'b1;
        poe[3] = m_upd[11] ? m_upd[14] : core_oe[3];
        push(1, ci, req);
        push(2, po, req);
        push(3, poe, req);
    endtask

    task automatic set_inputs(logic [NP-1:0] pi, logic [NP-1:0] co, logic [NP-1:0] coe);
        tick();
        pad_i   = pi;
        core_o  = co;
        core_oe = coe;
    endtask

    // shifts v in (highest index first) while reading back the old contents
    task automatic shift_chain(logic [L-1:0] v, string req);
        for (int t = 0; t < L; t++) begin
            tick();
            shift_en = 1'b1;
            tdi      = v[L-1-t];
            push(0, {3'b000, m_sh[L-1-t]}, req);
        end
        tick();
        shift_en = 1'b0;
        m_sh = v;
    endtask

    task automatic do_update();
        tick();
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
        m_upd = m_sh;
    endtask

    task automatic model_capture();
        m_sh     = m_upd;
        m_sh[1]  = pad_i[0];
        m_sh[5]  = core_o[1];
        m_sh[7]  = pad_i[2];
        m_sh[10] = core_o[2];
        m_sh[12] = pad_i[3];
        m_sh[16] = core_o[3];
        m_sh[17] = core_oe[3];
    endtask

    task automatic do_capture();
        tick();
        capture_en = 1'b1;
        model_capture();
        tick();
        capture_en = 1'b0;
    endtask

    localparam logic [L-1:0] CTRL_ALL = 18'h00849;   // bits 0,3,6,11

    initial begin
        #1 trst_n = 1'b0;
        repeat (3) tick();
        trst_n = 1'b1;
        tick();
        // R7: after reset every pin is transparent and the chain is empty
        check_pins("R7");
        shift_chain('0, "R7");

        // R2: transparency under several patterns; R9 fixed levels
        set_inputs(4'b1010, 4'b0110, 4'b1000); check_pins("R2");
        set_inputs(4'b0101, 4'b1001, 4'b0000); check_pins("R9");
        set_inputs(4'b1111, 4'b1111, 4'b1111); check_pins("R2");

        // R2: chain holds ones but control bits clear -> no effect
        shift_chain(18'h3FFFF & ~CTRL_ALL, "R5");
        do_update();
        check_pins("R2");
        set_inputs(4'b0000, 4'b0000, 4'b0000); check_pins("R2");

        // R3, R8: redirect every pin with a mixed pattern
        shift_chain(18'h2A5B6 | CTRL_ALL, "R5");
        do_update();
        check_pins("R8");
        set_inputs(4'b1111, 4'b1111, 4'b1111); check_pins("R3");
        set_inputs(4'b0110, 4'b1001, 4'b0101); check_pins("R3");

        // R6: shifting without update leaves the pins alone
        shift_chain(18'h15A3C, "R5");
        check_pins("R6");
        // R6: capture beats a simultaneous update
        tick();
        capture_en = 1'b1;
        update_en  = 1'b1;
        model_capture();
        tick();
        capture_en = 1'b0;
        update_en  = 1'b0;
        check_pins("R6");

        // R4: capture new side values and read them back serially
        set_inputs(4'b1101, 4'b1010, 4'b1000);
        do_capture();
        // R1: redirect only the tristate pin (ctrl at bit 11)
        shift_chain(18'h0A800 | 18'h00800, "R4");
        do_update();
        check_pins("R1");
        set_inputs(4'b0010, 4'b0101, 4'b0000); check_pins("R1");
        do_capture();
        shift_chain(18'h00000, "R4");
        do_update();
        check_pins("R2");

        // R7: reset while redirected
        shift_chain(CTRL_ALL | 18'h3F0F0, "R5");
        do_update();
        check_pins("R3");
        tick();
        trst_n = 1'b0;
        tick();
        trst_n = 1'b1;
        m_sh  = '0;
        m_upd = '0;
        check_pins("R7");
        shift_chain('0, "R7");

        tick();
        tick();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule